// File: doc/BRIEF.md
# Memory Block Copy and Search Sequencer

This sequencer walks through memory one byte at a time under control of a source pointer, a destination pointer and a 16-bit byte counter. In copy mode each step reads the byte at the source pointer and writes it to the destination pointer. In search mode each step compares a byte-wide accumulator value with the byte at the source pointer and writes nothing. Both modes can walk upward or downward through memory. They can also stop after one step or keep repeating on their own.

The caller loads the pointers, the counter, the accumulator and the incoming flag byte, then pulses `start`. The block drives a synchronous single-port memory: the read data returns one clock after the address. When it stops it pulses `done`. The final pointers, counter and flag byte stay on the outputs until the next start.

Top module: `blkmove_seq`

## Requirements
- R1: A copy step reads the byte at the source pointer, writes that byte to the destination pointer, and decrements the counter by one.
- R2: With `dir_down`=0 each step adds one to the pointers. With `dir_down`=1 each step subtracts one. In copy mode both pointers move. In search mode only the source pointer moves and `dst_out` keeps its loaded value.
- R3: A repeating copy runs until the counter reaches 0. When it finishes, flag bits 4 (half-carry), 2 (parity/overflow) and 1 (subtract) are all 0.
- R4: A search step never writes memory. It compares the accumulator with the byte at the source pointer and decrements the counter.
- R5: A repeating search stops after the first step whose byte equals the accumulator, or after the step that brings the counter to 0, whichever comes first.
- R6: After a search step the flags are set from acc minus byte, as follows:
  - bit 7 is bit 7 of the difference;
  - bit 6 is 1 exactly when the byte equals the accumulator;
  - bit 4 is 1 when the accumulator's low nibble is smaller than the byte's low nibble;
  - bit 1 is 1;
  - bit 0 keeps its loaded value.
- R7: After every step in either mode, flag bit 2 is 1 if the counter is nonzero and 0 if it is zero.
- R8: Every step takes exactly three clocks. `done` is a one-clock pulse that appears 3·N clocks after the clock edge that samples `start`, where N is the number of steps. `busy` is high from that edge until `done`.
- R9: A starting counter of 0 means 65536 bytes. One step from 0 leaves the counter at 0xFFFF with flag bit 2 set.
- R10: A `start` pulse seen while `busy` is high is ignored. The operation already running finishes as if that pulse had never come.
- R11: In copy mode, flag bits 7, 6, 5, 3 and 0 keep their loaded values. In search mode, bits 5 and 3 keep theirs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_search | input | 1 | 0 = copy, 1 = search |
| dir_down | input | 1 | 0 = pointers increment, 1 = pointers decrement |
| repeat_en | input | 1 | 1 = repeat until a stop condition |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial byte counter (0 means 65536) |
| acc_in | input | 8 | Accumulator value for search |
| flags_in | input | 8 | Incoming flag byte |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| src_out | output | 16 | Current or final source pointer |
| dst_out | output | 16 | Current or final destination pointer |
| cnt_out | output | 16 | Current or final counter |
| flags_out | output | 8 | Current or final flag byte |

## Verification
The assertions check several rules on every cycle:
- writes happen only in copy mode;
- `done` never lasts longer than one clock;
- each update phase lowers the counter by exactly one and leaves the carry bit alone;
- a finished repeating copy ends with bits 4, 2 and 1 clear;
- a finished search has the subtract bit set.

Other behaviour can only be shown by the bench's scenarios, which compare against a byte-by-byte model:
- the right bytes landing at the right addresses when source and destination overlap;
- the exact stopping point of a repeating search;
- the nibble-borrow and sign bits;
- the three-clock step count;
- the wrap of a zero counter;
- the ignored mid-run start.

// File: rtl/blkmove_seq.sv
module blkmove_seq #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_search,
  input  logic          dir_down,
  input  logic          repeat_en,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [DW-1:0] acc_in,
  input  logic [7:0]    flags_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [CW-1:0] cnt_out,
  output logic [7:0]    flags_out
);
  localparam logic [AW-1:0] P1 = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] C1 = {{(CW-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_XF, ST_UP} st_t;
  st_t st;

  logic          op_q, down_q, rep_q, done_q;
  logic [DW-1:0] acc_q, dat_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    flg_q;

  wire [CW-1:0] cnt_nx = cnt_q - C1;
  wire [AW-1:0] src_nx = down_q ? src_q - P1 : src_q + P1;
  wire [AW-1:0] dst_nx = down_q ? dst_q - P1 : dst_q + P1;
  wire [DW-1:0] diff   = acc_q - dat_q;
  wire          hit    = (acc_q == dat_q);
  wire          hbor   = (acc_q[3:0] < dat_q[3:0]);
  wire          nz     = (cnt_nx != '0);
  wire          more   = rep_q && nz && !(op_q && hit);

  logic [7:0] flg_nx;
  always_comb begin
    flg_nx = flg_q;
    flg_nx[2] = nz;
    if (op_q) begin
      flg_nx[7] = diff[DW-1];
      flg_nx[6] = hit;
      flg_nx[4] = hbor;
      flg_nx[1] = 1'b1;
    end else begin
      flg_nx[4] = 1'b0;
      flg_nx[1] = 1'b0;
    end
  end

  assign mem_addr  = (st == ST_XF && !op_q) ? dst_q : src_q;
  assign mem_we    = (st == ST_XF) && !op_q;
  assign mem_wdata = mem_rdata;
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign src_out   = src_q;
  assign dst_out   = dst_q;
  assign cnt_out   = cnt_q;
  assign flags_out = flg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= 1'b0;
      down_q <= 1'b0;
      rep_q  <= 1'b0;
      done_q <= 1'b0;
      acc_q  <= '0;
      dat_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      flg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_RD;
          op_q   <= op_search;
          down_q <= dir_down;
          rep_q  <= repeat_en;
          acc_q  <= acc_in;
          src_q  <= src_in;
          dst_q  <= dst_in;
          cnt_q  <= cnt_in;
          flg_q  <= flags_in;
        end
        ST_RD: st <= ST_XF;
        ST_XF: begin
          dat_q <= mem_rdata;
          st    <= ST_UP;
        end
        default: begin
          src_q <= src_nx;
          if (!op_q) dst_q <= dst_nx;
          cnt_q <= cnt_nx;
          flg_q <= flg_nx;
          if (more) st <= ST_RD;
          else begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_WRITE_ONLY_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy && !op_q); // R4
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_COUNT_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UP) |=> cnt_out == $past(cnt_out) - C1); // R1
  AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UP) |=> flags_out[0] == $past(flags_out[0])); // R6
  AST_COPY_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q && rep_q) |-> (flags_out[4] == 1'b0 && flags_out[2] == 1'b0 && flags_out[1] == 1'b0)); // R3
  AST_SEARCH_SUB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |-> flags_out[1]); // R6
  AST_PARITY_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out[2] == (cnt_out != '0))); // R7
endmodule

// File: tb/sim_blkmove_seq.sv
module sim_blkmove_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 0, op_search = 0, dir_down = 0, repeat_en = 0;
  logic [15:0] src_in = 0, dst_in = 0, cnt_in = 0;
  logic [7:0]  acc_in = 0, flags_in = 0;
  logic [15:0] mem_addr, src_out, dst_out, cnt_out;
  logic        mem_we, busy, done;
  logic [7:0]  mem_wdata, mem_rdata, flags_out;

  blkmove_seq u0 (.clk, .rst_n, .start, .op_search, .dir_down, .repeat_en,
    .src_in, .dst_in, .cnt_in, .acc_in, .flags_in, .mem_addr, .mem_we,
    .mem_wdata, .mem_rdata, .busy, .done, .src_out, .dst_out, .cnt_out, .flags_out);

  logic [7:0] mem [0:4095];
  logic [7:0] refm [0:4095];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  int checks = 0, errors = 0;
  logic timed_out = 0;
  initial begin
    #1500000;
    timed_out = 1;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [15:0] e_src, e_dst, e_cnt;
  logic [7:0]  e_flg;
  int          e_steps;

  task automatic model(input logic op, input logic dn, input logic rp,
                       input logic [15:0] s0, input logic [15:0] d0, input logic [15:0] c0,
                       input logic [7:0] acc, input logic [7:0] f0);
    logic [15:0] s = s0, d = d0, c = c0;
    logic [7:0] f = f0, b, df;
    logic stop = 0;
    e_steps = 0;
    while (!stop) begin
      b = refm[s[11:0]];
      if (!op) begin
        refm[d[11:0]] = b;
        d = dn ? d - 1 : d + 1;
      end
      s = dn ? s - 1 : s + 1;
      c = c - 1;
      e_steps++;
      f[2] = (c != 0);
      if (op) begin
        df = acc - b;
        f[7] = df[7];
        f[6] = (acc == b);
        f[4] = (acc[3:0] < b[3:0]);
        f[1] = 1'b1;
      end else begin
        f[4] = 1'b0;
        f[1] = 1'b0;
      end
      stop = !rp || c == 0 || (op && acc == b);
    end
    e_src = s; e_dst = d; e_cnt = c; e_flg = f;
  endtask

  task automatic run(input logic op, input logic dn, input logic rp,
                     input logic [15:0] s0, input logic [15:0] d0, input logic [15:0] c0,
                     input logic [7:0] acc, input logic [7:0] f0, input bit stray);
    int cyc = 0;
    bit memok = 1;
    model(op, dn, rp, s0, d0, c0, acc, f0);
    @(negedge clk);
    op_search = op; dir_down = dn; repeat_en = rp;
    src_in = s0; dst_in = d0; cnt_in = c0; acc_in = acc; flags_in = f0;
    start = 1;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 0;
      if (stray && cyc == 2) begin
        // R10: mid-run start with different values must be ignored
        op_search = ~op; dir_down = ~dn; src_in = 16'h0F00; dst_in = 16'h0E00;
        cnt_in = 16'd3; flags_in = ~f0; start = 1;
      end
      if (done || timed_out) break;
      chk(busy, "R8 busy during run", busy, 1);
    end
    start = 0;
    chk(cyc == 3*e_steps + 1, "R8 step timing", cyc, 3*e_steps + 1);
    chk(src_out == e_src, op ? "R2 R4 search src" : "R1 R2 copy src", src_out, e_src);
    chk(dst_out == e_dst, op ? "R2 search dst held" : "R2 copy dst", dst_out, e_dst);
    chk(cnt_out == e_cnt, op ? "R5 R9 counter" : "R3 R9 counter", cnt_out, e_cnt);
    chk(flags_out == e_flg, op ? "R6 R7 R11 search flags" : "R3 R7 R11 copy flags", flags_out, e_flg);
    for (int i = 0; i < 4096; i++) if (mem[i] !== refm[i]) memok = 0;
    chk(memok, op ? "R4 memory untouched" : "R1 memory contents", memok, 1);
    @(negedge clk);
    chk(!done && !busy, "R8 done pulse one clock", {busy, done}, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'($urandom % 8);
      refm[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(!busy && !done && cnt_out == 0 && flags_out == 0, "R8 reset state", {busy, done, cnt_out}, 0);

    // R1 R2 single copy up, single copy down
    run(0, 0, 0, 16'h0100, 16'h0800, 16'd5, 8'h00, 8'hFF, 0);
    run(0, 1, 0, 16'h0200, 16'h0900, 16'd1, 8'h00, 8'h29, 0);
    // R3 repeating copy, both directions, overlapping regions
    run(0, 0, 1, 16'h0300, 16'h0302, 16'd12, 8'h00, 8'hD7, 0);
    run(0, 1, 1, 16'h0410, 16'h040E, 16'd10, 8'h00, 8'h16, 0);
    // R5 search matching on the first byte
    mem[12'h500] = 8'h42; refm[12'h500] = 8'h42;
    run(1, 0, 1, 16'h0500, 16'h0000, 16'd9, 8'h42, 8'h01, 0);
    // R5 search exhausting the counter with no match
    run(1, 1, 1, 16'h0610, 16'h1234, 16'd6, 8'h99, 8'h00, 0);
    // R6 nibble borrow and sign on a single search
    mem[12'h700] = 8'h0F; refm[12'h700] = 8'h0F;
    run(1, 0, 0, 16'h0700, 16'h0000, 16'd4, 8'h01, 8'h28, 0);
    // R9 zero counter wraps
    run(0, 0, 0, 16'h0710, 16'h0720, 16'd0, 8'h00, 8'h00, 0);
    run(1, 0, 0, 16'h0730, 16'h0000, 16'd0, 8'h03, 8'h00, 0);
    // R10 stray start while busy
    run(0, 0, 1, 16'h0740, 16'h0780, 16'd8, 8'h00, 8'h44, 1);
    run(1, 1, 1, 16'h07C0, 16'h0000, 16'd8, 8'h77, 8'h00, 1);

    for (int k = 0; k < 40; k++) begin
      logic [15:0] s = 16'(12'h800 + ($urandom % 1024));
      logic [15:0] d = 16'(12'hC00 + ($urandom % 512));
      run(1'($urandom), 1'($urandom), 1'($urandom), s, d, 16'(1 + $urandom % 20),
          8'($urandom % 8), 8'($urandom), 1'($urandom));
    end

    if (timed_out) chk(0, "R8 watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule